// File: doc/BRIEF.md
# FFT Twiddle Angle Generator

This block produces the twiddle rotation angle for one stage of a pipelined N-point FFT, one angle per clock. It needs no coefficient memory. The angle comes straight from the FFT control counter, which runs from 0 to N-1. The counter field that belongs to the stage is split into two parts: a multiplier digit `p` at the top and an index `k` below it. The product `p*k` is then scaled to the smallest FFT angle with a fixed left shift.

The output is an angle index `m` in units of 2*pi/N. The rotation that follows applies -2*pi*m/N radians. N and the radix are powers of two, and the stage is a build-time parameter. Stage 1 is the input stage when the FFT is decimation-in-time and the output stage when it is decimation-in-frequency, so both orderings use the same block. The angle is registered. A valid flag follows the counter enable one cycle later.

Top module: `twid_angle_gen`

## Requirements
- R1: While `rst_ni` is low, `angle_o` and `valid_o` are 0.
- R2: `valid_o` equals the value `cnt_en_i` had at the previous clock edge.
- R3: When the digit p is 0, the angle produced is 0. Here f = cnt mod r^s and p = f / r^(s-1).
- R4: After a clock edge with `cnt_en_i` high, `angle_o` = (p * k * N / r^s) mod N for the sampled counter value. Here k = f mod r^(s-1), and r^s is the period.
- R5: Counter bits at and above position s*log2(r) have no effect on the angle, so the sequence repeats every r^s counts.
- R6: The low log2(N/r^s) bits of `angle_o` are always 0.
- R7: After a clock edge with `cnt_en_i` low, `angle_o` keeps its previous value.
- R8: At stage 1 every angle is 0.
- R9: At the last stage, s = log_r(N), the product is applied without a shift.
- R10: Radix 2 and radix 4 both give the sequence of R4. Radix 2 uses gating and radix 4 uses shifts and one adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | The counter value is valid this cycle |
| cnt_i | input | log2(N) | FFT control counter, 0 to N-1 |
| angle_o | output | log2(N) | Angle index m, in units of 2*pi/N |
| valid_o | output | 1 | `angle_o` holds a fresh angle |

## Verification
On every cycle, the assertions check four things: the one-cycle delay from enable to valid, that the angle holds while the enable is low, that a zero digit yields a zero angle, and that the low bits cleared by the normalising shift stay zero. The actual angle values can only be shown by the bench's scenarios. The bench sweeps the full counter range for several radix, N and stage settings and compares each output with a behavioural model of the sequence. Those sweeps cover the stage-1 and last-stage corners, the periodicity over r^s, and idle gaps with a changing counter.

// File: rtl/twid_pkg.sv
package twid_pkg;
  function automatic int field_w(input int log_r, input int stage);
    return log_r * stage;
  endfunction

  // index width, kept at least 1 so stage 1 has no zero-width vectors
  function automatic int k_w(input int log_r, input int stage);
    return (stage > 1) ? log_r * (stage - 1) : 1;
  endfunction
endpackage

// File: rtl/twid_field_split.sv
module twid_field_split #(
  parameter int LOG_N = 10,
  parameter int LOG_R = 2,
  parameter int STAGE = 3,
  localparam int FIELD_W = twid_pkg::field_w(LOG_R, STAGE),
  localparam int KW      = twid_pkg::k_w(LOG_R, STAGE),
  localparam int IDX_W   = FIELD_W - LOG_R
) (
  input  logic [LOG_N-1:0] cnt_i,
  output logic [LOG_R-1:0] p_o,
  output logic [KW-1:0]    k_o
);
  localparam logic [LOG_N-1:0] FIELD_MASK = LOG_N'((1 << FIELD_W) - 1);

  logic [LOG_N-1:0] field;
  assign field = cnt_i & FIELD_MASK;
  assign p_o   = LOG_R'(field >> IDX_W);

  generate
    if (STAGE > 1) begin : g_idx
      assign k_o = KW'(field);
    end else begin : g_no_idx
      assign k_o = '0;
    end
  endgenerate
endmodule

// File: rtl/twid_digit_mult.sv
module twid_digit_mult #(
  parameter int RADIX = 4,
  parameter int KW    = 4,
  localparam int LOG_R = $clog2(RADIX),
  localparam int PW    = LOG_R + KW
) (
  input  logic [LOG_R-1:0] p_i,
  input  logic [KW-1:0]    k_i,
  output logic [PW-1:0]    prod_o
);
  generate
    if (RADIX == 2) begin : g_r2
      assign prod_o = p_i[0] ? {1'b0, k_i} : '0;
    end else if (RADIX == 4) begin : g_r4
      logic [PW-1:0] k1, k2, k3;
      assign k1 = PW'(k_i);
      assign k2 = {k_i, 1'b0};
      assign k3 = k2 + k1;
      always_comb begin
        unique case (p_i)
          2'd0:    prod_o = '0;
          2'd1:    prod_o = k1;
          2'd2:    prod_o = k2;
          default: prod_o = k3;
        endcase
      end
    end else begin : g_generic
      assign prod_o = PW'(p_i) * PW'(k_i);
    end
  endgenerate
endmodule

// File: rtl/twid_angle_gen.sv
module twid_angle_gen #(
  parameter int N_PTS = 1024,
  parameter int RADIX = 4,
  parameter int STAGE = 3,
  localparam int LOG_N   = $clog2(N_PTS),
  localparam int LOG_R   = $clog2(RADIX),
  localparam int FIELD_W = twid_pkg::field_w(LOG_R, STAGE),
  localparam int KW      = twid_pkg::k_w(LOG_R, STAGE),
  localparam int PW      = LOG_R + KW,
  localparam int SHIFT   = LOG_N - FIELD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [LOG_N-1:0] cnt_i,
  output logic [LOG_N-1:0] angle_o,
  output logic             valid_o
);
  logic [LOG_R-1:0]    p;
  logic [KW-1:0]       k;
  logic [PW-1:0]       prod;
  logic [LOG_N+PW-1:0] scaled;
  logic [LOG_N-1:0]    angle_d;

  twid_field_split #(.LOG_N(LOG_N), .LOG_R(LOG_R), .STAGE(STAGE)) u_split (
    .cnt_i(cnt_i), .p_o(p), .k_o(k)
  );

  twid_digit_mult #(.RADIX(RADIX), .KW(KW)) u_mult (
    .p_i(p), .k_i(k), .prod_o(prod)
  );

  // normalise to 2*pi/N; mod N by truncation
  assign scaled  = {{LOG_N{1'b0}}, prod} << SHIFT;
  assign angle_d = scaled[LOG_N-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      angle_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cnt_en_i;
      if (cnt_en_i) angle_o <= angle_d;
    end
  end

  AST_VALID_FOLLOWS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |=> valid_o); // R2
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> !valid_o); // R2
  AST_ANGLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(angle_o)); // R7
  AST_ZERO_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && p == '0) |=> angle_o == '0); // R3

  generate
    if (SHIFT > 0) begin : g_low_chk
      AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> angle_o[SHIFT-1:0] == '0); // R6
    end
  endgenerate
endmodule

// File: tb/twid_angle_gen_tb.sv
module twid_angle_gen_tb;
  localparam int NCFG = 7;
  localparam int CFG_N [NCFG] = '{64, 64, 64, 256, 256, 256, 1024};
  localparam int CFG_R [NCFG] = '{2, 2, 2, 4, 4, 4, 4};
  localparam int CFG_S [NCFG] = '{1, 3, 6, 1, 2, 4, 3};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [9:0] cnt = '0;
  logic [9:0] ang [NCFG];
  logic       vld [NCFG];

  int n_chk = 0;
  int n_fail = 0;
  int exp_ang [NCFG];
  logic last_en = 1'b0;
  int last_cnt = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_dut
    localparam int LN = $clog2(CFG_N[g]);
    logic [LN-1:0] a;
    twid_angle_gen #(.N_PTS(CFG_N[g]), .RADIX(CFG_R[g]), .STAGE(CFG_S[g])) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .cnt_i(cnt[LN-1:0]),
      .angle_o(a), .valid_o(vld[g])
    );
    assign ang[g] = 10'(a);
  end

  function automatic int model(input int n, input int r, input int s, input int c);
    int rs, rs1, f, p, k;
    rs  = r ** s;
    rs1 = rs / r;
    f   = (c % n) % rs;
    p   = f / rs1;
    k   = f % rs1;
    return (p * k * (n / rs)) % n;
  endfunction

  task automatic check(input string req, input int got, input int exp, input int cfg);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s cfg%0d: actual %0d expected %0d", req, cfg, got, exp);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NCFG; i++) begin
      int n, r, s, rs, p;
      string tag;
      n = CFG_N[i]; r = CFG_R[i]; s = CFG_S[i]; rs = r ** s;
      p = ((last_cnt % n) % rs) / (rs / r);
      check("R2", int'(vld[i]), int'(last_en), i);
      if (last_en) begin
        exp_ang[i] = model(n, r, s, last_cnt);
        if (s == 1) tag = "R8";
        else if (p == 0) tag = "R3";
        else if (rs == n) tag = "R9";
        else if ((last_cnt % n) >= rs) tag = "R5";
        else tag = "R4 R10";
      end else tag = "R7";
      check(tag, int'(ang[i]), exp_ang[i], i);
      check("R6", int'(ang[i]) % (n / rs), 0, i);
    end
  endtask

  task automatic step(input logic e, input int c);
    @(negedge clk);
    compare_all();
    en = e;
    cnt = 10'(c);
    last_en = e;
    last_cnt = c;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCFG; i++) exp_ang[i] = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NCFG; i++) begin
      check("R1", int'(ang[i]), 0, i);
      check("R1", int'(vld[i]), 0, i);
    end
    rst_n = 1'b1;
    // full sweep, ascending
    for (int c = 0; c < 1024; c++) step(1'b1, c);
    // idle with moving counter: angles must hold
    for (int c = 0; c < 40; c++) step(1'b0, (c * 37 + 5) % 1024);
    // descending sweep with gaps
    for (int c = 1023; c >= 0; c--) step((c % 5) != 0, c);
    // scattered values
    for (int c = 0; c < 500; c++) step((c % 3) != 1, (c * 613 + 11) % 1024);
    step(1'b0, 0);
    step(1'b0, 0);
    finish_run();
  end
endmodule